// File: doc/BRIEF.md
# CCK Eight-Chip Codeword Encoder

This block turns data bits into complementary-code-keying spread symbols for the 5.5 and 11 Mbps rates. It accepts one symbol's worth of bits through a valid/ready handshake. It then emits eight complex chips, one per clock, over a chip-valid output. The first chip it emits is chip 0, the least significant one. A rate select input chooses how many input bits the symbol carries: 8 in the fast mode and 4 in the slow mode.

Every chip phase is a sum of four phase terms, held as 2-bit quadrant codes (0 = 0°, 1 = 90°, 2 = 180°, 3 = 270°) and added modulo 4. The common term φ1 is differential. It advances the φ1 of the previous symbol by a DQPSK step, so the block keeps φ1 as a reference from one symbol to the next. Each chip's quadrant is mapped onto an axis-aligned signed I/Q pair. A new symbol can be accepted on the clock that shows the last chip of the current one, so a stream of symbols runs with no gap.

Top module: `cck_chip_encoder`

## Requirements
- R1: After reset, chip_valid is 0, in_ready is 1, chip_i and chip_q are 0, and the φ1 reference is quadrant 0.
- R2: in_ready is 1 while no symbol is being emitted and on the cycle that shows chip 7. It is 0 on the cycles that show chips 0 to 6. A symbol is accepted on a rising edge where in_valid and in_ready are both 1.
- R3: After an acceptance edge, chips 0 to 7 appear with chip_valid high on the next eight cycles. If the next symbol is accepted at the edge that ends chip 7, its chip 0 follows with no gap. Otherwise chip_valid falls.
- R4: For chip index k, the quadrant is: k0 = φ1+φ2+φ3+φ4, k1 = φ1+φ3+φ4, k2 = φ1+φ2+φ4, k3 = φ1+φ4+2, k4 = φ1+φ2+φ3, k5 = φ1+φ3, k6 = φ1+φ2+2, k7 = φ1. All sums are taken modulo 4.
- R5: in_bits[0] is the first bit in time. φ1 = previous φ1 + step, where the step comes from the dibit code {in_bits[0], in_bits[1]}: 00 gives 0, 01 gives 1, 11 gives 2 and 10 gives 3. The reference is kept across idle gaps.
- R6: With rate_hi = 1, φ2 = {in_bits[2], in_bits[3]}, φ3 = {in_bits[4], in_bits[5]} and φ4 = {in_bits[6], in_bits[7]}, each read as an unsigned quadrant number.
- R7: With rate_hi = 0, φ2 = {in_bits[2], 1} (quadrant 1 or 3), φ3 = 0 and φ4 = {in_bits[3], 0} (quadrant 0 or 2). in_bits[7:4] have no effect.
- R8: Quadrant 0 maps to (I, Q) = (+AMP, 0), quadrant 1 to (0, +AMP), quadrant 2 to (-AMP, 0) and quadrant 3 to (0, -AMP). The default AMP is 1.
- R9: chip_i and chip_q are 0 whenever chip_valid is 0.
- R10: rate_hi and in_bits are sampled only at acceptance. Changing them while a symbol is being emitted does not alter its chips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_bits | input | 8 | Symbol bits; bit 0 is first in time |
| in_valid | input | 1 | in_bits and rate_hi hold a symbol |
| in_ready | output | 1 | The encoder can take a symbol this cycle |
| rate_hi | input | 1 | 1 = 8 bits per symbol, 0 = 4 bits per symbol |
| chip_valid | output | 1 | chip_i and chip_q carry a chip |
| chip_i | output | IQ_W (2) | Signed in-phase chip value |
| chip_q | output | IQ_W (2) | Signed quadrature chip value |

## Verification
The assertions assume that in_valid and the symbol bits are driven away from the active clock edge. They also assume that a symbol may be offered at any time, with the block's own in_ready deciding when it is taken. No other rule is placed on the source. The stimulus changes its inputs on the falling edge. It raises in_valid only on a cycle where the bench model predicts in_ready. It inverts in_bits and rate_hi in the middle of each symbol, so the sampling rule is exercised without leaving the expected protocol.

// File: rtl/cck_pkg.sv
package cck_pkg;
   typedef logic [1:0] quad_t;

   localparam int unsigned CHIPS_PER_SYM = 8;
   localparam int unsigned SYM_BITS_MAX  = 8;

   // DQPSK phase step for the first dibit, code {first, second}
   function automatic quad_t dqpsk_step(input logic first, input logic second);
      case ({first, second})
         2'b00:   return 2'd0;
         2'b01:   return 2'd1;
         2'b11:   return 2'd2;
         default: return 2'd3;
      endcase
   endfunction
endpackage

// File: rtl/cck_phase_map.sv
module cck_phase_map
   import cck_pkg::*;
#(
   parameter int unsigned CHIPS = CHIPS_PER_SYM,
   parameter int unsigned NBITS = SYM_BITS_MAX
) (
   input  logic [NBITS-1:0]         bits,
   input  logic                     rate_hi,
   input  quad_t                    ref_ph1,
   output quad_t                    new_ph1,
   output logic [CHIPS-1:0][1:0]    chip_quad
);
   generate
      if (CHIPS != 8) begin : g_bad_chips
         $error("cck_phase_map: CHIPS must be 8");
      end
      if (NBITS != 8) begin : g_bad_bits
         $error("cck_phase_map: NBITS must be 8");
      end
   endgenerate

   quad_t ph2, ph3, ph4;

   assign new_ph1 = ref_ph1 + dqpsk_step(bits[0], bits[1]);

   always_comb begin
      if (rate_hi) begin
         ph2 = {bits[2], bits[3]};
         ph3 = {bits[4], bits[5]};
         ph4 = {bits[6], bits[7]};
      end else begin
         ph2 = {bits[2], 1'b1};
         ph3 = 2'd0;
         ph4 = {bits[3], 1'b0};
      end
   end

   // chip k takes phi2 when k bit0 is 0, phi3 when bit1 is 0, phi4 when bit2 is 0,
   // and an extra half turn for k = 3 and k = 6
   generate
      for (genvar k = 0; k < CHIPS; k++) begin : g_chip
         localparam bit USE2 = ((k % 2) == 0);
         localparam bit USE3 = (((k / 2) % 2) == 0);
         localparam bit USE4 = (((k / 4) % 2) == 0);
         localparam bit FLIP = (k == 3) || (k == 6);
         quad_t t2, t3, t4, tf;
         assign t2 = USE2 ? ph2 : 2'd0;
         assign t3 = USE3 ? ph3 : 2'd0;
         assign t4 = USE4 ? ph4 : 2'd0;
         assign tf = FLIP ? 2'd2 : 2'd0;
         assign chip_quad[k] = new_ph1 + t2 + t3 + t4 + tf;
      end
   endgenerate
endmodule

// File: rtl/cck_chip_serializer.sv
module cck_chip_serializer
   import cck_pkg::*;
#(
   parameter int unsigned CHIPS = CHIPS_PER_SYM
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic [CHIPS-1:0][1:0] chips_in,
   input  quad_t                 ref_ph1,
   output quad_t                 cur_quad,
   output logic                  active,
   output logic                  last
);
   localparam int unsigned CW = (CHIPS > 1) ? $clog2(CHIPS) : 1;
   localparam logic [CW-1:0] LAST_IDX = CW'(CHIPS - 1);

   generate
      if (CHIPS < 2) begin : g_bad
         $error("cck_chip_serializer: CHIPS must be at least 2");
      end
   endgenerate

   logic [CHIPS-1:0][1:0] vec;
   logic [CW-1:0]         cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec    <= '0;
         cnt    <= '0;
         active <= 1'b0;
      end else if (load) begin
         vec    <= chips_in;
         cnt    <= '0;
         active <= 1'b1;
      end else if (active) begin
         if (cnt == LAST_IDX) begin
            active <= 1'b0;
            cnt    <= '0;
         end else begin
            cnt <= CW'(cnt + 1'b1);
         end
      end
   end

   assign last     = active && (cnt == LAST_IDX);
   assign cur_quad = vec[cnt];

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !last && !load) |=> (active && cnt == CW'($past(cnt) + 1'b1))) // R3
      else $error("chip index did not advance");

   AST_LAST_IS_REF: assert property (@(posedge clk) disable iff (!rst_n)
      last |-> (cur_quad == ref_ph1)) // R4
      else $error("chip 7 differs from phi1");
endmodule

// File: rtl/cck_quad_to_iq.sv
module cck_quad_to_iq
   import cck_pkg::*;
#(
   parameter int unsigned IQ_W = 2,
   parameter int unsigned AMP  = 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   en,
   input  quad_t                  quad,
   output logic signed [IQ_W-1:0] out_i,
   output logic signed [IQ_W-1:0] out_q
);
   generate
      if (IQ_W < 2) begin : g_bad_w
         $error("cck_quad_to_iq: IQ_W must be at least 2");
      end
      if (AMP < 1 || AMP >= (1 << (IQ_W - 1))) begin : g_bad_amp
         $error("cck_quad_to_iq: AMP out of range for IQ_W");
      end
   endgenerate

   localparam logic signed [IQ_W-1:0] POS = IQ_W'(AMP);
   localparam logic signed [IQ_W-1:0] NEG = -POS;

   always_comb begin
      out_i = '0;
      out_q = '0;
      if (en) begin
         case (quad)
            2'd0:    out_i = POS;
            2'd1:    out_q = POS;
            2'd2:    out_i = NEG;
            default: out_q = NEG;
         endcase
      end
   end

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (out_i == '0 && out_q == '0)) // R9
      else $error("chip output not zero while idle");

   AST_ON_AXIS: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> ((out_i != '0) != (out_q != '0))) // R8
      else $error("chip not on a single axis");
endmodule

// File: rtl/cck_chip_encoder.sv
module cck_chip_encoder
   import cck_pkg::*;
#(
   parameter int unsigned IQ_W = 2,
   parameter int unsigned AMP  = 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [7:0]             in_bits,
   input  logic                   in_valid,
   output logic                   in_ready,
   input  logic                   rate_hi,
   output logic                   chip_valid,
   output logic signed [IQ_W-1:0] chip_i,
   output logic signed [IQ_W-1:0] chip_q
);
   localparam int unsigned CHIPS = CHIPS_PER_SYM;
   localparam int unsigned NBITS = SYM_BITS_MAX;

   quad_t                 ref_ph1, next_ph1, cur_quad;
   logic [CHIPS-1:0][1:0] chip_quad;
   logic                  active, last, accept;

   assign in_ready = !active || last;
   assign accept   = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ref_ph1 <= 2'd0;
      else if (accept) ref_ph1 <= next_ph1;
   end

   cck_phase_map #(.CHIPS(CHIPS), .NBITS(NBITS)) u_map (
      .bits      (in_bits),
      .rate_hi   (rate_hi),
      .ref_ph1   (ref_ph1),
      .new_ph1   (next_ph1),
      .chip_quad (chip_quad)
   );

   cck_chip_serializer #(.CHIPS(CHIPS)) u_ser (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .chips_in (chip_quad),
      .ref_ph1  (ref_ph1),
      .cur_quad (cur_quad),
      .active   (active),
      .last     (last)
   );

   assign chip_valid = active;

   cck_quad_to_iq #(.IQ_W(IQ_W), .AMP(AMP)) u_iq (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (active),
      .quad  (cur_quad),
      .out_i (chip_i),
      .out_q (chip_q)
   );

   AST_READY_MIDSYM: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !last) |-> !in_ready) // R2
      else $error("ready raised mid-symbol");

   AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (chip_valid && !in_ready)) // R3
      else $error("accepted symbol did not start");

   AST_REF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> $stable(ref_ph1)) // R5
      else $error("phi1 reference moved without a symbol");
endmodule

// File: tb/sim_cck_chip_encoder.sv
module sim_cck_chip_encoder;
   localparam int AMP = 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [7:0]        in_bits = '0;
   logic              in_valid = 1'b0;
   logic              in_ready;
   logic              rate_hi = 1'b0;
   logic              chip_valid;
   logic signed [1:0] chip_i, chip_q;

   int checks = 0;
   int errors = 0;
   logic [1:0] ref_model = 2'd0;
   int exp_q [8];

   always #2 clk = ~clk;

   cck_chip_encoder #(.IQ_W(2), .AMP(AMP)) u0 (
      .clk(clk), .rst_n(rst_n), .in_bits(in_bits), .in_valid(in_valid),
      .in_ready(in_ready), .rate_hi(rate_hi), .chip_valid(chip_valid),
      .chip_i(chip_i), .chip_q(chip_q)
   );

   // {rate_hi, in_bits}
   localparam logic [8:0] VEC [10] = '{
      9'h100, 9'h1FF, 9'h1A5, 9'h13C, 9'h0F0, 9'h00F, 9'h0A6, 9'h159, 9'h0C3, 9'h1E1
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int dq(input logic a, input logic b);
      case ({a, b})
         2'b00: return 0;
         2'b01: return 1;
         2'b11: return 2;
         default: return 3;
      endcase
   endfunction

   // expected chip quadrants per R4..R7
   task automatic model(input logic rate, input logic [7:0] b);
      int p1, p2, p3, p4;
      p1 = (int'(ref_model) + dq(b[0], b[1])) % 4;
      ref_model = 2'(p1);
      if (rate) begin
         p2 = 2 * b[2] + b[3]; p3 = 2 * b[4] + b[5]; p4 = 2 * b[6] + b[7];
      end else begin
         p2 = 2 * b[2] + 1; p3 = 0; p4 = 2 * b[3];
      end
      exp_q[0] = (p1 + p2 + p3 + p4) % 4;
      exp_q[1] = (p1 + p3 + p4) % 4;
      exp_q[2] = (p1 + p2 + p4) % 4;
      exp_q[3] = (p1 + p4 + 2) % 4;
      exp_q[4] = (p1 + p2 + p3) % 4;
      exp_q[5] = (p1 + p3) % 4;
      exp_q[6] = (p1 + p2 + 2) % 4;
      exp_q[7] = p1;
   endtask

   task automatic chk_chip(input string req, input int q);
      int ei, eq;
      ei = (q == 0) ? AMP : (q == 2) ? -AMP : 0;
      eq = (q == 1) ? AMP : (q == 3) ? -AMP : 0;
      chk({req, " valid"}, int'(chip_valid), 1);
      chk({req, " I"}, int'(chip_i), ei);
      chk({req, " Q"}, int'(chip_q), eq);
   endtask

   // streams VEC[first..first+n-1] back to back; called at a negedge with the block idle
   task automatic stream(input int first, input int n);
      chk("R2 ready idle", int'(in_ready), 1);
      in_valid = 1'b1; rate_hi = VEC[first][8]; in_bits = VEC[first][7:0];
      model(VEC[first][8], VEC[first][7:0]);
      for (int s = 0; s < n; s++) begin
         for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (k == 0) begin
               in_valid = 1'b0;
               in_bits  = ~in_bits;   // R10: must not disturb this symbol
               rate_hi  = ~rate_hi;
            end
            chk_chip("R3 R4 R6 R7 R8 R10 chip", exp_q[k]);
            if (k == 7) begin
               chk("R2 ready on chip 7", int'(in_ready), 1);
               if (s < n - 1) begin
                  in_valid = 1'b1;
                  rate_hi  = VEC[first + s + 1][8];
                  in_bits  = VEC[first + s + 1][7:0];
                  model(VEC[first + s + 1][8], VEC[first + s + 1][7:0]);
               end
            end else begin
               chk("R2 ready mid-symbol", int'(in_ready), 0);
            end
         end
      end
      @(negedge clk);
      chk("R3 valid falls", int'(chip_valid), 0);
      chk("R9 I idle", int'(chip_i), 0);
      chk("R9 Q idle", int'(chip_q), 0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 valid", int'(chip_valid), 0);
      chk("R1 ready", int'(in_ready), 1);
      chk("R1 I", int'(chip_i), 0);
      chk("R1 Q", int'(chip_q), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // directed: zero bits from reset -> phi all 0; I = 1,1,1,-1,1,1,-1,1 (R4 R5 R1)
      in_valid = 1'b1; rate_hi = 1'b1; in_bits = 8'h00;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         in_valid = 1'b0;
         chk("R4 fixed I", int'(chip_i), (k == 3 || k == 6) ? -1 : 1);
         chk("R4 fixed Q", int'(chip_q), 0);
      end
      @(negedge clk);
      ref_model = 2'd0;

      // table walk, back to back (R2 R3 R4 R5 R6 R7 R8 R10)
      stream(0, 10);
      // idle gap keeps the phi1 reference (R5)
      repeat (5) @(negedge clk);
      chk("R9 idle I", int'(chip_i), 0);
      stream(2, 4);

      // reset clears the reference (R1 R5): dibit 01 from reset -> chip 7 at 90 deg
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 valid after reset", int'(chip_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      in_valid = 1'b1; rate_hi = 1'b0; in_bits = 8'hF2;   // R7: upper nibble ignored
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         in_valid = 1'b0;
         if (k == 7) begin
            chk("R5 chip7 I", int'(chip_i), 0);
            chk("R5 chip7 Q", int'(chip_q), 1);
         end
         if (k == 5) begin   // phi1+phi3 = 1+0 in slow mode
            chk("R7 chip5 Q", int'(chip_q), 1);
         end
      end
      @(negedge clk);
      chk("R3 end valid", int'(chip_valid), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule